// File: doc/BRIEF.md
# Directory-Coherent Cache Line Controller

This block is the cache-side controller of one processor in a system that keeps caches coherent through a home directory rather than a shared bus. It holds a small direct-mapped cache. Each line is Invalid, Shared (read-only) or Exclusive (read/write). The processor issues loads and stores. Misses and upgrades become explicit request messages to the home directory. The directory in turn sends invalidate, fetch and fetch-with-invalidate messages, which the controller answers with data write-backs when it owns the line.

The processor holds its request stable until the controller pulses a completion strobe, so every access blocks until its coherence traffic is finished. The low address bits select the line and the remaining bits form the tag. Outgoing messages carry a fixed processor number. The network accepts one message per cycle without back-pressure.

Top module: `dir_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_done` is low and no outgoing message is valid.
- R2: A load that misses sends one message of kind 0 (read miss) carrying the processor number and the request address. When an incoming reply of kind 3 arrives, the line becomes Shared, `cpu_rdata` returns the reply data and `cpu_done` pulses.
- R3: A store to an Invalid line, or to a line with another tag, sends kind 1 (write miss). On the reply the line becomes Exclusive and holds the store data.
- R4: A store that hits a Shared line sends kind 2 (invalidate request) for that address and leaves the line Exclusive with the store data.
- R5: A load hit in Shared or Exclusive, or a store hit in Exclusive, raises `cpu_done` in the cycle after the request is seen and sends no message.
- R6: An incoming invalidate (kind 0) whose address matches a valid line makes that line Invalid, so the next load to it misses.
- R7: An incoming fetch (kind 1) that matches an Exclusive line sends a write-back (outgoing kind 3) with the line's address and data, and leaves the line Shared.
- R8: An incoming fetch-with-invalidate (kind 2) that matches an Exclusive line sends the same write-back and leaves the line Invalid.
- R9: A miss whose line holds a different address in Exclusive sends the victim's write-back first, then the read or write miss in the next cycle.
- R10: An incoming invalidate, fetch or fetch-with-invalidate that matches no valid line is ignored. A fetch or fetch-with-invalidate that matches a Shared line is also ignored. An ignored message sends nothing and leaves the line unchanged.
- R11: An incoming directory message that arrives together with a new processor request is handled first. The request starts one cycle later.
- R12: `cpu_done` is a single-cycle pulse and is raised only once the whole access, with all of its messages and replies, has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request, held until `cpu_done` |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address; low IDX_W bits are the index |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_done` |
| msg_in_valid | input | 1 | Message from the directory |
| msg_in_type | input | 2 | 0 invalidate, 1 fetch, 2 fetch-invalidate, 3 data reply |
| msg_in_addr | input | ADDR_W | Block address of the incoming message |
| msg_in_data | input | DATA_W | Reply data |
| msg_out_valid | output | 1 | Message to the directory |
| msg_out_type | output | 2 | 0 read miss, 1 write miss, 2 invalidate request, 3 write-back |
| msg_out_pid | output | PID_W | Processor number |
| msg_out_addr | output | ADDR_W | Block address |
| msg_out_data | output | DATA_W | Write-back data |

## Verification
On every cycle the assertions check that fast hits finish in one cycle without traffic, and that an Exclusive victim is written back before its miss. They also check that a matching fetch on an owned line produces a write-back, that a reply fills a load's line as Shared, that a directory message stalls a waiting request, and that the completion strobe never lasts two cycles. Only the bench scenarios can show the content of the data: write-backs carry the newest store, and a line reloaded after fetch-with-invalidate returns the written-back value. The scenarios also show that invalidated lines truly miss again, that ignored messages leave hits intact, and the exact order of the messages in combined cases.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    LN_INVALID = 2'd0,
    LN_SHARED  = 2'd1,
    LN_EXCL    = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    OUT_RDMISS = 2'd0,
    OUT_WRMISS = 2'd1,
    OUT_INVREQ = 2'd2,
    OUT_WRBACK = 2'd3
  } out_kind_e;

  typedef enum logic [1:0] {
    IN_INVAL    = 2'd0,
    IN_FETCH    = 2'd1,
    IN_FETCHINV = 2'd2,
    IN_REPLY    = 2'd3
  } in_kind_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_EVICT = 2'd1,
    CS_WAIT  = 2'd2,
    CS_DONE  = 2'd3
  } ctl_st_e;
endpackage

// File: rtl/dcc_line_store.sv
module dcc_line_store
  import dcc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic              meta_we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_state,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wr_data,
  output line_st_e          a_state,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  output line_st_e          b_state,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_e          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  // line states need a reset; tags and data are plain RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INVALID;
    end else if (meta_we) begin
      st_q[wr_idx] <= wr_state;
    end
  end

  always_ff @(posedge clk) begin
    if (meta_we) tag_q[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (data_we) dat_q[wr_idx] <= wr_data;
  end

  assign a_state = st_q[rd_a_idx];
  assign a_tag   = tag_q[rd_a_idx];
  assign a_data  = dat_q[rd_a_idx];
  assign b_state = st_q[rd_b_idx];
  assign b_tag   = tag_q[rd_b_idx];
  assign b_data  = dat_q[rd_b_idx];
endmodule

// File: rtl/dcc_msg_out.sv
module dcc_msg_out
  import dcc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int PID_W   = 2,
  parameter int PROC_ID = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nxt_valid,
  input  out_kind_e         nxt_kind,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [DATA_W-1:0] nxt_data,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [PID_W-1:0]  out_pid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_pid   <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= nxt_valid;
      out_kind  <= nxt_kind;
      out_pid   <= PID_W'(PROC_ID);
      out_addr  <= nxt_addr;
      out_data  <= nxt_data;
    end
  end
endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              msg_in_valid,
  input  logic [1:0]        msg_in_type,
  input  logic [ADDR_W-1:0] msg_in_addr,
  input  logic [DATA_W-1:0] msg_in_data,
  output logic [IDX_W-1:0]  rd_a_idx,
  output logic [IDX_W-1:0]  rd_b_idx,
  input  line_st_e          a_state,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  input  line_st_e          b_state,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic [DATA_W-1:0] b_data,
  output logic              meta_we,
  output logic [IDX_W-1:0]  wr_idx,
  output line_st_e          wr_state,
  output logic [TAG_W-1:0]  wr_tag,
  output logic              data_we,
  output logic [DATA_W-1:0] wr_data,
  output logic              nxt_valid,
  output out_kind_e         nxt_kind,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [DATA_W-1:0] nxt_data,
  input  logic              out_valid_q,
  input  logic [1:0]        out_kind_q
);
  ctl_st_e           st_q, st_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rdata_we;

  logic [IDX_W-1:0] cpu_idx, in_idx;
  logic [TAG_W-1:0] cpu_tag, in_tag;
  in_kind_e         in_kind;
  logic             coh_req, reply_in, cpu_hit, in_match;
  out_kind_e        miss_kind;

  assign cpu_idx   = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag   = cpu_req_addr[ADDR_W-1:IDX_W];
  assign in_idx    = msg_in_addr[IDX_W-1:0];
  assign in_tag    = msg_in_addr[ADDR_W-1:IDX_W];
  assign in_kind   = in_kind_e'(msg_in_type);
  assign rd_a_idx  = cpu_idx;
  assign rd_b_idx  = in_idx;
  assign coh_req   = msg_in_valid && (in_kind != IN_REPLY);
  assign reply_in  = msg_in_valid && (in_kind == IN_REPLY);
  assign cpu_hit   = (a_state != LN_INVALID) && (a_tag == cpu_tag);
  assign in_match  = (b_state != LN_INVALID) && (b_tag == in_tag);
  assign miss_kind = cpu_req_write ? OUT_WRMISS : OUT_RDMISS;

  always_comb begin
    st_d      = st_q;
    meta_we   = 1'b0;
    wr_idx    = cpu_idx;
    wr_state  = a_state;
    wr_tag    = cpu_tag;
    data_we   = 1'b0;
    wr_data   = cpu_req_wdata;
    nxt_valid = 1'b0;
    nxt_kind  = OUT_RDMISS;
    nxt_addr  = cpu_req_addr;
    nxt_data  = '0;
    rdata_we  = 1'b0;
    rdata_d   = a_data;

    if (coh_req) begin
      // directory traffic wins; the processor side holds this cycle
      wr_idx = in_idx;
      wr_tag = b_tag;
      case (in_kind)
        IN_INVAL: begin
          if (in_match) begin
            meta_we  = 1'b1;
            wr_state = LN_INVALID;
          end
        end
        IN_FETCH, IN_FETCHINV: begin
          if (in_match && b_state == LN_EXCL) begin
            meta_we   = 1'b1;
            wr_state  = (in_kind == IN_FETCH) ? LN_SHARED : LN_INVALID;
            nxt_valid = 1'b1;
            nxt_kind  = OUT_WRBACK;
            nxt_addr  = msg_in_addr;
            nxt_data  = b_data;
          end
        end
        default: ;
      endcase
      if (st_q == CS_DONE) st_d = CS_IDLE;
    end else begin
      case (st_q)
        CS_IDLE: begin
          if (cpu_req_valid) begin
            if (cpu_hit && (!cpu_req_write || a_state == LN_EXCL)) begin
              data_we  = cpu_req_write;
              rdata_we = 1'b1;
              rdata_d  = cpu_req_write ? cpu_req_wdata : a_data;
              st_d     = CS_DONE;
            end else if (cpu_hit) begin
              meta_we   = 1'b1;
              wr_state  = LN_EXCL;
              data_we   = 1'b1;
              rdata_we  = 1'b1;
              rdata_d   = cpu_req_wdata;
              nxt_valid = 1'b1;
              nxt_kind  = OUT_INVREQ;
              st_d      = CS_DONE;
            end else begin
              // drop the old line now; its index stays blind until the fill
              meta_we  = 1'b1;
              wr_state = LN_INVALID;
              wr_tag   = a_tag;
              nxt_valid = 1'b1;
              if (a_state == LN_EXCL) begin
                nxt_kind = OUT_WRBACK;
                nxt_addr = {a_tag, cpu_idx};
                nxt_data = a_data;
                st_d     = CS_EVICT;
              end else begin
                nxt_kind = miss_kind;
                st_d     = CS_WAIT;
              end
            end
          end
        end
        CS_EVICT: begin
          nxt_valid = 1'b1;
          nxt_kind  = miss_kind;
          st_d      = CS_WAIT;
        end
        CS_WAIT: begin
          if (reply_in) begin
            meta_we  = 1'b1;
            wr_state = cpu_req_write ? LN_EXCL : LN_SHARED;
            data_we  = 1'b1;
            wr_data  = cpu_req_write ? cpu_req_wdata : msg_in_data;
            rdata_we = 1'b1;
            rdata_d  = cpu_req_write ? cpu_req_wdata : msg_in_data;
            st_d     = CS_DONE;
          end
        end
        default: st_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= CS_IDLE;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (rdata_we) rdata_q <= rdata_d;
    end
  end

  assign cpu_done  = (st_q == CS_DONE);
  assign cpu_rdata = rdata_q;

  // R11: a directory message keeps an idle controller idle
  p_coh_first_r11: assert property (@(posedge clk) disable iff (rst)
    (coh_req && st_q == CS_IDLE) |=> (st_q == CS_IDLE));

  // R5: fast hits finish next cycle with no traffic
  p_hit_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == CS_IDLE && !coh_req && cpu_req_valid && cpu_hit &&
     (!cpu_req_write || a_state == LN_EXCL))
    |=> (st_q == CS_DONE && !out_valid_q));

  // R9: an owned victim is written back before the miss goes out
  p_evict_first_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == CS_IDLE && !coh_req && cpu_req_valid && !cpu_hit && a_state == LN_EXCL)
    |=> (out_valid_q && out_kind_q == 2'd3 && st_q == CS_EVICT));

  // R7: a fetch on an owned line yields a write-back
  p_fetch_wb_r7: assert property (@(posedge clk) disable iff (rst)
    (coh_req && in_kind == IN_FETCH && in_match && b_state == LN_EXCL)
    |=> (out_valid_q && out_kind_q == 2'd3));

  // R2: a load fill leaves the line Shared
  p_fill_shared_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == CS_WAIT && reply_in && !cpu_req_write)
    |=> (st_q == CS_DONE && a_state == LN_SHARED));

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    (st_q == CS_DONE) |=> (st_q != CS_DONE));
endmodule

// File: rtl/dir_cache_ctrl.sv
module dir_cache_ctrl
  import dcc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 16,
  parameter int PID_W   = 2,
  parameter int PROC_ID = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              msg_in_valid,
  input  logic [1:0]        msg_in_type,
  input  logic [ADDR_W-1:0] msg_in_addr,
  input  logic [DATA_W-1:0] msg_in_data,
  output logic              msg_out_valid,
  output logic [1:0]        msg_out_type,
  output logic [PID_W-1:0]  msg_out_pid,
  output logic [ADDR_W-1:0] msg_out_addr,
  output logic [DATA_W-1:0] msg_out_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  rd_a_idx, rd_b_idx, wr_idx;
  line_st_e          a_state, b_state, wr_state;
  logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
  logic [DATA_W-1:0] a_data, b_data, wr_data;
  logic              meta_we, data_we;
  logic              nxt_valid;
  out_kind_e         nxt_kind;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_data;

  dcc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .meta_we(meta_we), .wr_idx(wr_idx), .wr_state(wr_state), .wr_tag(wr_tag),
    .data_we(data_we), .wr_data(wr_data),
    .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_state(b_state), .b_tag(b_tag), .b_data(b_data)
  );

  dcc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .msg_in_valid(msg_in_valid), .msg_in_type(msg_in_type),
    .msg_in_addr(msg_in_addr), .msg_in_data(msg_in_data),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
    .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
    .meta_we(meta_we), .wr_idx(wr_idx), .wr_state(wr_state), .wr_tag(wr_tag),
    .data_we(data_we), .wr_data(wr_data),
    .nxt_valid(nxt_valid), .nxt_kind(nxt_kind), .nxt_addr(nxt_addr), .nxt_data(nxt_data),
    .out_valid_q(msg_out_valid), .out_kind_q(msg_out_type)
  );

  dcc_msg_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PID_W(PID_W), .PROC_ID(PROC_ID)) u_out (
    .clk(clk), .rst(rst),
    .nxt_valid(nxt_valid), .nxt_kind(nxt_kind), .nxt_addr(nxt_addr), .nxt_data(nxt_data),
    .out_valid(msg_out_valid), .out_kind(msg_out_type), .out_pid(msg_out_pid),
    .out_addr(msg_out_addr), .out_data(msg_out_data)
  );
endmodule

// File: tb/sim_dir_cache_ctrl.sv
module sim_dir_cache_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0;
  logic        cpu_done;
  logic [15:0] cpu_rdata;
  logic        msg_in_valid = 1'b0;
  logic [1:0]  msg_in_type = '0;
  logic [7:0]  msg_in_addr = '0;
  logic [15:0] msg_in_data = '0;
  logic        msg_out_valid;
  logic [1:0]  msg_out_type;
  logic [1:0]  msg_out_pid;
  logic [7:0]  msg_out_addr;
  logic [15:0] msg_out_data;

  always #5 clk = ~clk;

  dir_cache_ctrl u0 (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .msg_in_valid(msg_in_valid), .msg_in_type(msg_in_type),
    .msg_in_addr(msg_in_addr), .msg_in_data(msg_in_data),
    .msg_out_valid(msg_out_valid), .msg_out_type(msg_out_type),
    .msg_out_pid(msg_out_pid), .msg_out_addr(msg_out_addr), .msg_out_data(msg_out_data)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [7:0]  req;
  } exp_msg_t;

  exp_msg_t    expq[$];
  int          checks = 0, fails = 0;
  logic [15:0] dir_mem [256];
  logic [15:0] cur_val [256];
  int          m_st  [4];
  logic [5:0]  m_tag [4];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic push(input int kind, input [7:0] addr, input [15:0] data, input [7:0] rq);
    exp_msg_t e;
    e.kind = 2'(kind); e.addr = addr; e.data = data; e.req = rq;
    expq.push_back(e);
  endtask

  // scoreboard monitor: every outgoing message must match the next expected one
  always @(negedge clk) begin
    if (!rst && msg_out_valid) begin
      if (expq.size() == 0) begin
        check(0, "R10 unexpected message kind/addr", {msg_out_type, msg_out_addr}, 0);
      end else begin
        exp_msg_t e;
        e = expq.pop_front();
        check(msg_out_type == e.kind, $sformatf("R%0d message kind", e.req), msg_out_type, e.kind);
        check(msg_out_addr == e.addr, $sformatf("R%0d message addr", e.req), msg_out_addr, e.addr);
        check(msg_out_pid == 2'd1, "R2 processor number", msg_out_pid, 1);
        if (e.kind == 2'd3) begin
          check(msg_out_data == e.data, $sformatf("R%0d write-back data", e.req), msg_out_data, e.data);
          dir_mem[msg_out_addr] = msg_out_data;
        end
      end
    end
  end

  // bench model of the line states, derived from the requirements
  task automatic model_coh(input int ctype, input [7:0] caddr, input [7:0] rq);
    int i;
    bit match;
    i = int'(caddr[1:0]);
    match = (m_st[i] != 0) && (m_tag[i] == caddr[7:2]);
    if (ctype == 0 && match) m_st[i] = 0;
    if (ctype == 1 && match && m_st[i] == 2) begin push(3, caddr, cur_val[caddr], rq); m_st[i] = 1; end
    if (ctype == 2 && match && m_st[i] == 2) begin push(3, caddr, cur_val[caddr], rq); m_st[i] = 0; end
  endtask

  task automatic cpu_op(input bit wr, input [7:0] addr, input [15:0] wd, input bit coh,
                        input int ctype, input [7:0] caddr, input [7:0] rq, input string tag);
    int i, n;
    bit hit, fast, done;
    if (coh) model_coh(ctype, caddr, 8'd11);
    i = int'(addr[1:0]);
    hit = (m_st[i] != 0) && (m_tag[i] == addr[7:2]);
    fast = hit && (!wr || m_st[i] == 2);
    if (fast) begin
    end else if (hit) begin
      push(2, addr, 0, 4); m_st[i] = 2;
    end else begin
      if (m_st[i] == 2) push(3, {m_tag[i], addr[1:0]}, cur_val[{m_tag[i], addr[1:0]}], 9);
      push(wr ? 1 : 0, addr, 0, wr ? 3 : 2);
      m_st[i] = wr ? 2 : 1; m_tag[i] = addr[7:2];
    end
    if (wr) cur_val[addr] = wd;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = wd;
    if (coh) begin msg_in_valid = 1'b1; msg_in_type = 2'(ctype); msg_in_addr = caddr; end
    n = 0; done = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      msg_in_valid = 1'b0;
      n++;
      if (cpu_done) done = 1;
      else if (msg_out_valid && msg_out_type <= 2'd1) begin
        msg_in_valid = 1'b1; msg_in_type = 2'd3;
        msg_in_addr = msg_out_addr; msg_in_data = dir_mem[msg_out_addr];
      end
    end
    cpu_req_valid = 1'b0;
    check(done, {"R12 completion seen: ", tag}, done, 1);
    if (fast) check(n == (coh ? 2 : 1), {"R5/R11 hit latency: ", tag}, n, coh ? 2 : 1);
    check(cpu_rdata == cur_val[addr], $sformatf("R%0d data: %s", rq, tag), cpu_rdata, cur_val[addr]);
    @(negedge clk);
    check(!cpu_done, {"R12 single pulse: ", tag}, cpu_done, 0);
    repeat (2) @(negedge clk);
    check(expq.size() == 0, $sformatf("R%0d all messages sent: %s", rq, tag), expq.size(), 0);
  endtask

  task automatic dir_msg(input int ctype, input [7:0] caddr, input [7:0] rq, input string tag);
    model_coh(ctype, caddr, rq);
    @(negedge clk);
    msg_in_valid = 1'b1; msg_in_type = 2'(ctype); msg_in_addr = caddr;
    @(negedge clk);
    msg_in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(expq.size() == 0, $sformatf("R%0d directory message: %s", rq, tag), expq.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      dir_mem[a] = 16'(a * 7 + 16'h100);
      cur_val[a] = dir_mem[a];
    end
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check(!cpu_done, "R1 done low after reset", cpu_done, 0);
    check(!msg_out_valid, "R1 no message after reset", msg_out_valid, 0);

    cpu_op(0, 8'h05, 0, 0, 0, 0, 2, "R1/R2 read miss on reset line");
    cpu_op(0, 8'h05, 0, 0, 0, 0, 5, "R5 read hit shared");
    cpu_op(1, 8'h05, 16'hA1A1, 0, 0, 0, 4, "R4 write hit shared");
    cpu_op(1, 8'h05, 16'hB2B2, 0, 0, 0, 5, "R5 write hit exclusive");
    dir_msg(1, 8'h05, 7, "R7 fetch on exclusive");
    cpu_op(0, 8'h05, 0, 0, 0, 0, 7, "R7 line shared after fetch");
    cpu_op(1, 8'h05, 16'hC3C3, 0, 0, 0, 4, "R4 upgrade again");
    dir_msg(2, 8'h05, 8, "R8 fetch-invalidate");
    cpu_op(0, 8'h05, 0, 0, 0, 0, 8, "R8 reload returns written-back value");

    cpu_op(1, 8'h0A, 16'h1234, 0, 0, 0, 3, "R3 write miss");
    cpu_op(0, 8'h0A, 0, 0, 0, 0, 3, "R3 line exclusive with store data");
    cpu_op(0, 8'h1A, 0, 0, 0, 0, 9, "R9 read evicts exclusive line");
    dir_msg(0, 8'h1A, 6, "R6 invalidate");
    cpu_op(0, 8'h1A, 0, 0, 0, 0, 6, "R6 line misses after invalidate");
    dir_msg(0, 8'h2A, 10, "R10 invalidate with other tag");
    dir_msg(1, 8'h1A, 10, "R10 fetch on shared line");
    dir_msg(2, 8'h33, 10, "R10 fetch-invalidate on invalid line");
    cpu_op(0, 8'h1A, 0, 0, 0, 0, 10, "R10 line intact after ignored messages");

    cpu_op(1, 8'h07, 16'h5555, 0, 0, 0, 3, "R3 write miss idx3");
    cpu_op(1, 8'h07, 16'h6666, 1, 1, 8'h07, 11, "R11 fetch with concurrent store");
    cpu_op(0, 8'h07, 0, 1, 0, 8'h1A, 11, "R11 invalidate with concurrent read hit");
    cpu_op(1, 8'h17, 16'h7777, 0, 0, 0, 9, "R9 write evicts exclusive line");
    cpu_op(0, 8'h07, 0, 0, 0, 0, 9, "R9 evicted value reached memory");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule